// File: doc/BRIEF.md
# Spill/Fill Tag Collection Unit

This unit moves 64-bit register values to and from memory for spill and fill operations. Each value travels with a one-bit deferred-exception tag that marks it as "not a thing" (NaT). The tag does not go to memory. A spill stores the value and records its tag in a 64-bit tag collection register. A fill loads the value and returns it together with the tag read from that same register.

The bit of the collection register used for a tag is chosen by the memory address, never by the register number. The word offset inside a 512-byte region (address bits 8:3) selects one of the 64 bits. A value must therefore be filled from an address that is congruent, modulo 512, to the address it was spilled to. The unit does not save the collection register itself. Software reads it continuously on a dedicated output and can overwrite it with a write strobe, so it can preserve the register around a context change.

The unit does not save or restore speculative-load tracking state. Instead, it pulses an invalidate output naming the filled register, so that external tracking for that register can be cleared.

The command, memory request and fill result ports are valid/ready streams:
- A transfer happens on a cycle where valid and ready are both high.
- A source holding valid high must keep its payload stable until that transfer.
- Only one command is in flight at a time. `cmd_ready` is high only while the unit is idle.
- The memory response has no ready signal. It must arrive one or more cycles after its read request is accepted, and only for that read.

Top module: `natcol_unit`

## Requirements
- R1: An accepted spill whose address has bits 2:0 equal to zero (`cmd_fill`=0) issues exactly one memory request with `mreq_write`=1, `mreq_addr` equal to the command address and `mreq_wdata` equal to `cmd_data`.
- R2: The collection bit used by a spill or fill is address bits 8:3. The register index has no influence on which bit is used.
- R3: In the cycle the spill's write request is accepted, the indexed collection bit takes `cmd_nat`. No other bit changes from the spill.
- R4: An accepted aligned fill (`cmd_fill`=1) issues one request with `mreq_write`=0 and the command address. When the response arrives, the unit presents `fill_data` equal to the response data, `fill_nat` equal to the indexed collection bit at that cycle, and `fill_reg` equal to the command register. A fill never changes the collection register.
- R5: One cycle after a fill response, `inval_valid` is high for exactly one cycle, with `inval_reg` equal to the filled register. This is the same cycle the fill result first becomes valid.
- R6: A command whose address bits 2:0 are not all zero is accepted but dropped. It causes no memory request and no collection change, and `err_misalign` is high for exactly the next cycle.
- R7: When `sw_wr_en` is high with no spill update in the same cycle, `coll_q` equals `sw_wdata` from the next cycle on.
- R8: When a software write and a spill update fall in the same cycle, the indexed bit takes the spill tag and every other bit takes `sw_wdata`.
- R9: `cmd_ready` is high exactly when no command is in flight. A request or fill result stays valid and stable while its ready input is low.
- R10: After reset, `coll_q` is zero, `cmd_ready` is 1 and `mreq_valid`, `fill_valid`, `inval_valid` and `err_misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_fill | input | 1 | 0 = spill, 1 = fill |
| cmd_reg | input | 7 | Register index |
| cmd_addr | input | 32 | Byte address of the 8-byte slot |
| cmd_data | input | 64 | Value to spill |
| cmd_nat | input | 1 | Tag to spill |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_write | output | 1 | 1 = write (spill), 0 = read (fill) |
| mreq_addr | output | 32 | Memory address |
| mreq_wdata | output | 64 | Write data |
| mrsp_valid | input | 1 | Read response valid |
| mrsp_rdata | input | 64 | Read response data |
| fill_valid | output | 1 | Fill result valid |
| fill_ready | input | 1 | Fill result taken |
| fill_reg | output | 7 | Filled register index |
| fill_data | output | 64 | Filled value |
| fill_nat | output | 1 | Restored tag |
| inval_valid | output | 1 | Invalidate pulse for speculation tracking |
| inval_reg | output | 7 | Register to invalidate |
| err_misalign | output | 1 | One-cycle pulse after a dropped misaligned command |
| sw_wr_en | input | 1 | Software write strobe for the collection register |
| sw_wdata | input | 64 | Software write value |
| coll_q | output | 64 | Current collection register |

## Verification
The bench builds the unit with its default parameters: 64-bit values, 32-bit addresses, 7-bit register indexes and a 512-byte region of 8-byte slots. These defaults make every one of the 64 collection bits reachable from addresses in four separate 512-byte regions. Aliasing across regions, and indexes unrelated to the register number, therefore show up directly. Random ready stalls on both streams, random response delays and software writes landing on the exact cycle of a spill update exercise the hold rules and the merge priority.

// File: rtl/natcol_pkg.sv
package natcol_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} nc_state_e;
endpackage

// File: rtl/natcol_index.sv
module natcol_index #(
  parameter int ADDR_W  = 32,
  parameter int OFF_LSB = 3,
  parameter int IDX_W   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              misalign
);
  // slot number inside the region: pure address offset, no register number
  assign idx      = addr[OFF_LSB +: IDX_W];
  assign misalign = |addr[OFF_LSB-1:0];
endmodule

// File: rtl/natcol_reg.sv
module natcol_reg #(
  parameter int COLL_W = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [COLL_W-1:0] sw_wdata,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_bit,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_bit,
  output logic [COLL_W-1:0] coll_q
);
  logic [COLL_W-1:0] upd_mask;

  always_comb begin
    upd_mask = '0;
    if (upd_en) upd_mask = COLL_W'(1) << upd_idx;
  end

  // per-bit merge: spill update beats software write on its own bit only
  for (genvar b = 0; b < COLL_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           coll_q[b] <= 1'b0;
      else if (upd_mask[b]) coll_q[b] <= upd_bit;
      else if (sw_we)       coll_q[b] <= sw_wdata[b];
    end
  end

  assign rd_bit = coll_q[rd_idx];

  AST_SPILL_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> coll_q[$past(upd_idx)] == $past(upd_bit)); // R3
  AST_SPILL_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !sw_we |=> ((coll_q ^ $past(coll_q)) & ~$past(upd_mask)) == '0); // R3
  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we && !upd_en |=> coll_q == $past(sw_wdata)); // R7
  AST_SW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we && upd_en |=> ((coll_q ^ $past(sw_wdata)) & ~$past(upd_mask)) == '0); // R8
endmodule

// File: rtl/natcol_ctrl.sv
module natcol_ctrl
  import natcol_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int REG_W  = 7,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_fill,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_nat,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic              cmd_misalign,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [DATA_W-1:0] mreq_wdata,
  input  logic              mrsp_valid,
  input  logic [DATA_W-1:0] mrsp_rdata,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [REG_W-1:0]  fill_reg,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_nat,
  output logic              inval_valid,
  output logic [REG_W-1:0]  inval_reg,
  output logic              err_misalign,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic              upd_bit,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_bit
);
  nc_state_e         state;
  logic              fill_q;
  logic [REG_W-1:0]  reg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              nat_q;
  logic [IDX_W-1:0]  idx_q;
  logic              err_q;
  logic              inval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fill_q  <= 1'b0;
      reg_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      nat_q   <= 1'b0;
      idx_q   <= '0;
      err_q   <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      err_q   <= 1'b0;
      inval_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (cmd_valid) begin
          if (cmd_misalign) begin
            err_q <= 1'b1;
          end else begin
            fill_q <= cmd_fill;
            reg_q  <= cmd_reg;
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            nat_q  <= cmd_nat;
            idx_q  <= cmd_idx;
            state  <= ST_REQ;
          end
        end
        ST_REQ: if (mreq_ready) state <= fill_q ? ST_WAIT : ST_IDLE;
        ST_WAIT: if (mrsp_valid) begin
          data_q  <= mrsp_rdata;
          nat_q   <= rd_bit;
          inval_q <= 1'b1;
          state   <= ST_OUT;
        end
        ST_OUT: if (fill_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (state == ST_IDLE);
  assign mreq_valid   = (state == ST_REQ);
  assign mreq_write   = !fill_q;
  assign mreq_addr    = addr_q;
  assign mreq_wdata   = data_q;
  assign fill_valid   = (state == ST_OUT);
  assign fill_reg     = reg_q;
  assign fill_data    = data_q;
  assign fill_nat     = nat_q;
  assign inval_valid  = inval_q;
  assign inval_reg    = reg_q;
  assign err_misalign = err_q;
  assign upd_en       = (state == ST_REQ) && mreq_ready && !fill_q;
  assign upd_idx      = idx_q;
  assign upd_bit      = nat_q;
  assign rd_idx       = idx_q;

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr)
      && $stable(mreq_wdata) && $stable(mreq_write)); // R9
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && !fill_ready |=> fill_valid && $stable(fill_data)
      && $stable(fill_nat) && $stable(fill_reg)); // R9
  AST_INVAL_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> fill_valid && $past(mrsp_valid)); // R5
  AST_MISALIGN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    err_misalign |-> cmd_ready && !mreq_valid); // R6
endmodule

// File: rtl/natcol_unit.sv
module natcol_unit #(
  parameter int DATA_W       = 64,
  parameter int ADDR_W       = 32,
  parameter int REG_W        = 7,
  parameter int REGION_BYTES = 512,
  parameter int WORD_BYTES   = 8,
  localparam int COLL_W  = REGION_BYTES / WORD_BYTES,
  localparam int IDX_W   = $clog2(COLL_W),
  localparam int OFF_LSB = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_fill,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_nat,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_write,
  output logic [ADDR_W-1:0] mreq_addr,
  output logic [DATA_W-1:0] mreq_wdata,
  input  logic              mrsp_valid,
  input  logic [DATA_W-1:0] mrsp_rdata,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [REG_W-1:0]  fill_reg,
  output logic [DATA_W-1:0] fill_data,
  output logic              fill_nat,
  output logic              inval_valid,
  output logic [REG_W-1:0]  inval_reg,
  output logic              err_misalign,
  input  logic              sw_wr_en,
  input  logic [COLL_W-1:0] sw_wdata,
  output logic [COLL_W-1:0] coll_q
);
  logic [IDX_W-1:0] cmd_idx;
  logic             cmd_misalign;
  logic             upd_en;
  logic [IDX_W-1:0] upd_idx;
  logic             upd_bit;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_bit;

  natcol_index #(.ADDR_W(ADDR_W), .OFF_LSB(OFF_LSB), .IDX_W(IDX_W)) u_index (
    .addr(cmd_addr), .idx(cmd_idx), .misalign(cmd_misalign)
  );

  natcol_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_fill(cmd_fill),
    .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_nat(cmd_nat),
    .cmd_idx(cmd_idx), .cmd_misalign(cmd_misalign),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
    .mrsp_valid(mrsp_valid), .mrsp_rdata(mrsp_rdata),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_reg(fill_reg),
    .fill_data(fill_data), .fill_nat(fill_nat),
    .inval_valid(inval_valid), .inval_reg(inval_reg), .err_misalign(err_misalign),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_bit(upd_bit),
    .rd_idx(rd_idx), .rd_bit(rd_bit)
  );

  natcol_reg #(.COLL_W(COLL_W), .IDX_W(IDX_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_wr_en), .sw_wdata(sw_wdata),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_bit(upd_bit),
    .rd_idx(rd_idx), .rd_bit(rd_bit), .coll_q(coll_q)
  );
endmodule

// File: tb/natcol_unit_bench.sv
module natcol_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_fill = 1'b0, cmd_nat = 1'b0;
  logic [6:0]  cmd_reg = '0;
  logic [31:0] cmd_addr = '0;
  logic [63:0] cmd_data = '0;
  logic        cmd_ready, mreq_valid, mreq_write, fill_valid, fill_nat;
  logic        mreq_ready = 1'b1, mrsp_valid = 1'b0, fill_ready = 1'b1;
  logic [31:0] mreq_addr;
  logic [63:0] mreq_wdata, fill_data, coll_q;
  logic [63:0] mrsp_rdata = '0;
  logic [6:0]  fill_reg, inval_reg;
  logic        inval_valid, err_misalign;
  logic        sw_wr_en = 1'b0;
  logic [63:0] sw_wdata = '0;

  always #10 clk = ~clk;

  natcol_unit u_natcol_unit (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_fill(cmd_fill),
    .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_nat(cmd_nat),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
    .mrsp_valid(mrsp_valid), .mrsp_rdata(mrsp_rdata),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_reg(fill_reg),
    .fill_data(fill_data), .fill_nat(fill_nat),
    .inval_valid(inval_valid), .inval_reg(inval_reg), .err_misalign(err_misalign),
    .sw_wr_en(sw_wr_en), .sw_wdata(sw_wdata), .coll_q(coll_q)
  );

  typedef struct packed {
    logic fill; logic [6:0] rg; logic [31:0] addr; logic [63:0] data; logic nat;
  } cmd_t;
  typedef struct packed { logic [6:0] rg; logic [63:0] data; logic nat; } res_t;

  int n_cmp = 0, n_bad = 0;
  int mode = 0;
  bit done = 0;
  cmd_t cq[$];
  res_t fq[$];
  logic [63:0] mem [logic [31:0]];
  logic [63:0] m_coll = '0;
  logic        m_err = 0, m_inval = 0;
  logic [6:0]  m_inval_reg = '0;
  logic        rd_out = 0;
  cmd_t        rd_cmd;
  logic        rsp_pend = 0;
  int          rsp_delay = 0;
  logic [63:0] rsp_data = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a, ~a};
  endfunction

  // reference model, evaluated a quarter period before each rising edge
  always begin
    @(negedge clk); #5;
    if (!rst_n) begin
      m_coll = '0; m_err = 0; m_inval = 0; rd_out = 0;
      cq.delete(); fq.delete();
    end else begin
      logic [63:0] n_coll;
      chk(coll_q == m_coll, "R7 coll_q", coll_q, m_coll);
      chk(err_misalign == m_err, "R6 err_misalign", 64'(err_misalign), 64'(m_err));
      chk(inval_valid == m_inval, "R5 inval_valid", 64'(inval_valid), 64'(m_inval));
      if (m_inval) chk(inval_reg == m_inval_reg, "R5 inval_reg", 64'(inval_reg), 64'(m_inval_reg));
      chk(cmd_ready == (cq.size() == 0 && !rd_out && fq.size() == 0), "R9 cmd_ready",
          64'(cmd_ready), 64'(cq.size() == 0 && !rd_out && fq.size() == 0));
      if (fill_valid) begin
        if (fq.size() == 0) chk(0, "R4 unexpected fill_valid", 64'd1, 64'd0);
        else begin
          chk(fill_data == fq[0].data, "R4 fill_data", fill_data, fq[0].data);
          chk(fill_nat == fq[0].nat, "R4 fill_nat", 64'(fill_nat), 64'(fq[0].nat));
          chk(fill_reg == fq[0].rg, "R4 fill_reg", 64'(fill_reg), 64'(fq[0].rg));
        end
      end
      n_coll = sw_wr_en ? sw_wdata : m_coll;
      if (mreq_valid && mreq_ready) begin
        if (cq.size() == 0) chk(0, "R6 unexpected mreq", 64'(mreq_addr), 64'd0);
        else begin
          cmd_t c;
          c = cq.pop_front();
          chk(mreq_write == !c.fill, c.fill ? "R4 mreq_write" : "R1 mreq_write",
              64'(mreq_write), 64'(!c.fill));
          chk(mreq_addr == c.addr, "R1 mreq_addr", 64'(mreq_addr), 64'(c.addr));
          if (!c.fill) begin
            chk(mreq_wdata == c.data, "R1 mreq_wdata", mreq_wdata, c.data);
            mem[c.addr] = c.data;
            n_coll[c.addr[8:3]] = c.nat;
          end else begin
            rd_out = 1; rd_cmd = c;
            rsp_data = mem_rd(c.addr);
            rsp_delay = $urandom % 4;
            rsp_pend = 1;
          end
        end
      end
      m_err = cmd_valid && cmd_ready && (cmd_addr[2:0] != 3'b0);
      if (cmd_valid && cmd_ready && cmd_addr[2:0] == 3'b0)
        cq.push_back('{cmd_fill, cmd_reg, cmd_addr, cmd_data, cmd_nat});
      m_inval = 0;
      if (mrsp_valid && rd_out) begin
        fq.push_back('{rd_cmd.rg, mrsp_rdata, m_coll[rd_cmd.addr[8:3]]});
        m_inval = 1; m_inval_reg = rd_cmd.rg; rd_out = 0;
      end
      if (fill_valid && fill_ready && fq.size() > 0) void'(fq.pop_front());
      m_coll = n_coll;
    end
  end

  // memory responder and ready drivers
  initial forever begin
    @(negedge clk);
    if (rsp_pend && rsp_delay == 0) begin
      mrsp_valid = 1; mrsp_rdata = rsp_data; rsp_pend = 0;
    end else begin
      mrsp_valid = 0;
      if (rsp_pend) rsp_delay--;
    end
    if (mode == 0) begin mreq_ready = 1; fill_ready = 1; end
    else if (mode == 1) begin mreq_ready = ($urandom % 3) != 0; fill_ready = ($urandom % 2) != 0; end
    else fill_ready = 1;
  end

  task automatic do_cmd(input logic f, input logic [6:0] r, input logic [31:0] a,
                        input logic [63:0] d, input logic n);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_fill = f; cmd_reg = r; cmd_addr = a; cmd_data = d; cmd_nat = n;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic sw_write(input logic [63:0] v);
    @(negedge clk);
    sw_wr_en = 1; sw_wdata = v;
    @(negedge clk);
    sw_wr_en = 0;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (k < 6) begin
      @(negedge clk);
      if (cmd_ready && !rsp_pend) k++; else k = 0;
    end
  endtask

  task automatic conflict(input logic [31:0] a, input logic n, input logic [63:0] sw,
                          input logic [63:0] exp);
    mode = 2; mreq_ready = 0;
    do_cmd(0, 7'd12, a, 64'h1111_2222_3333_4444, n);
    sw_wr_en = 1; sw_wdata = sw; mreq_ready = 1;
    @(negedge clk);
    sw_wr_en = 0; mreq_ready = 0;
    chk(coll_q == exp, "R8 sw/spill merge", coll_q, exp);
    mode = 0;
    wait_idle();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(coll_q == 64'd0, "R10 coll_q reset", coll_q, 64'd0);
    chk(cmd_ready && !mreq_valid && !fill_valid && !inval_valid && !err_misalign,
        "R10 idle outputs", {59'd0, cmd_ready, mreq_valid, fill_valid, inval_valid, err_misalign},
        64'h10);

    do_cmd(0, 7'd5, 32'h0000_1018, 64'hCAFE_0000_0000_0005, 1);
    wait_idle();
    chk(coll_q == 64'h8, "R3 spill sets bit 3 only", coll_q, 64'h8);
    do_cmd(0, 7'd100, 32'h0000_2018, 64'h0000_0000_0000_0064, 0);
    wait_idle();
    chk(coll_q == 64'h0, "R2 other reg same offset clears bit 3", coll_q, 64'h0);
    do_cmd(0, 7'd5, 32'h0000_2020, 64'h0000_0000_0000_0505, 1);
    wait_idle();
    chk(coll_q == 64'h10, "R2 same reg new offset uses bit 4", coll_q, 64'h10);

    do_cmd(1, 7'd9, 32'h0000_5020, 64'd0, 0);
    while (!fill_valid) @(negedge clk);
    chk(fill_nat == 1'b1, "R4 fill tag from bit 4", 64'(fill_nat), 64'd1);
    chk(inval_valid && inval_reg == 7'd9, "R5 invalidate reg 9", 64'(inval_reg), 64'd9);
    wait_idle();
    chk(coll_q == 64'h10, "R4 fill leaves collection", coll_q, 64'h10);

    do_cmd(0, 7'd2, 32'h0000_1003, 64'd7, 0);
    chk(err_misalign == 1'b1, "R6 misaligned flag", 64'(err_misalign), 64'd1);
    wait_idle();
    chk(coll_q == 64'h10, "R6 misaligned no change", coll_q, 64'h10);

    sw_write(64'hDEAD_BEEF_0123_4567);
    chk(coll_q == 64'hDEAD_BEEF_0123_4567, "R7 software write", coll_q, 64'hDEAD_BEEF_0123_4567);
    do_cmd(0, 7'd1, 32'h0000_01F8, 64'd9, 1);
    wait_idle();
    chk(coll_q == 64'hDEAD_BEEF_0123_4567 | 64'h8000_0000_0000_0000, "R3 top bit",
        coll_q, 64'hDEAD_BEEF_0123_4567 | 64'h8000_0000_0000_0000);

    sw_write(64'h0);
    conflict(32'h0000_3028, 1, 64'h0, 64'h20);
    conflict(32'h0000_30F0, 0, '1, ~(64'h1 << 30));

    mode = 1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = 32'h0001_0000 + 32'(($urandom % 4) * 512) + 32'(($urandom % 64) * 8);
      if ($urandom % 8 == 0) a = a + 32'(1 + $urandom % 7);
      if ($urandom % 10 == 0) sw_write({$urandom, $urandom});
      do_cmd(1'($urandom % 2), 7'($urandom), a, {$urandom, $urandom}, 1'($urandom));
    end
    mode = 0;
    wait_idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule